// File: doc/BRIEF.md
# Byte-Loaded Shift and Normalize Unit

This block is a slice of an arithmetic coprocessor that holds a 32-bit operand in four byte registers and performs a logical left shift, a logical right shift or a normalize on it. A processor loads the operand one byte at a time over a simple byte bus, from the least significant byte upwards. It then writes a control byte that picks the direction and the shift distance, and that write starts the operation. A distance of zero selects normalize: the operand moves left until its top bit is one, and the number of places moved is written back into the distance field.

The engine does not finish in one clock. One clock is one machine cycle. The first cycle moves the operand by up to four places and every later cycle moves it by up to six, so the longest shift takes six cycles. A `busy` output is high for exactly those cycles. The control byte also carries two flags that only hardware can change. The overflow flag reports a normalize that was started on an operand whose top bit was already set. The error flag reports a broken access sequence: an operand register touched while the engine runs, an operand loaded or read out of order, a read-out interrupted by a write, or a start without a complete load. Reading the control byte clears the error flag.

Top module: `shnorm_unit`

## Requirements
- R1: After reset all four operand bytes read 0x00, the control byte reads 0x00 and `busy` is low.
- R2: Bus addresses 0 to 3 select operand bytes MD0 (bits 7:0) to MD3 (bits 31:24). Address 4 selects the control byte, laid out as: bit 7 error flag, bit 6 overflow flag, bit 5 direction (0 left, 1 right), bits 4:0 distance. `bus_rdata` shows the selected register in the same cycle. A write to address 4 starts an operation. The written bits 7 and 6 have no effect.
- R3: A nonzero distance N shifts the operand N places in the chosen direction and fills with zeros. The distance field keeps N.
- R4: `busy` rises on the clock edge that takes the start write. It stays high for 1 cycle when N is 4 or less, and for 1 + ceil((N-4)/6) cycles otherwise, which gives 6 cycles for N = 31. The result is readable once `busy` is low.
- R5: With distance 0, the operand is shifted left until bit 31 is 1, and the distance field then reads the number of places moved. The direction bit does not affect the result. An all-zero operand stays zero, the field reads 0 and `busy` lasts 1 cycle.
- R6: A normalize started while bit 31 of the operand is 1 sets the overflow flag and leaves the operand unchanged with a distance field of 0. Any other start clears the overflow flag.
- R7: A read or write of any operand byte while `busy` is high sets the error flag. Such a write leaves the operand unchanged.
- R8: A start sets the error flag if the operand bytes written since the previous start were not MD0, MD1, MD2, MD3 in that order. It also sets the flag if a read-out of the operand begun with MD0 has not yet reached MD3.
- R9: Writing or reading an operand byte other than MD0 sets the error flag unless it directly follows the next-lower byte in the same kind of sequence. An access to MD0 always begins a new sequence.
- R10: A write to any operand byte while a read-out is partway through (MD0 read, MD3 not yet read) sets the error flag.
- R11: The error flag stays set until the control byte is read. That read returns the flag still set, and the flag is clear from the next cycle.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select: 0 to 3 operand bytes, 4 control byte |
| bus_wr | input | 1 | Write strobe, takes priority over bus_rd |
| bus_rd | input | 1 | Read strobe, drives the sequence checker |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | High while the engine is shifting |

## Verification
Two things can fall in the same cycle: the last shifting cycle of an operation, and an operand access that the sequence checker must flag. The bench provokes this by starting a four-place shift and reading MD0 on the very next edge, which is the single cycle in which `busy` is high. It then expects two results together: the shifted result is correct in every byte, and the control byte shows the error flag once and clears it on the following read. The scoreboard matches every checked read against a value computed from the requirements, including normalize counts and busy lengths taken from the 4-then-6 schedule.

// File: rtl/shnorm_pkg.sv
package shnorm_pkg;

    // Bus address width and the control register location
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd4;

    // Control byte field positions
    localparam int CTL_ERR = 7;
    localparam int CTL_OVF = 6;
    localparam int CTL_DIR = 5;

endpackage

// File: rtl/shnorm_lzc.sv
module shnorm_lzc #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val,
    output logic [CNT_W-1:0] lz
);

    // Leading zero count; an all-zero operand reports zero
    always_comb begin
        lz = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (val[i]) lz = CNT_W'(WIDTH - 1 - i);
        end
    end

endmodule

// File: rtl/shnorm_engine.sv
module shnorm_engine #(
    parameter int WIDTH      = 32,
    parameter int FIRST_STEP = 4,
    parameter int NEXT_STEP  = 6,
    parameter int CNT_W      = $clog2(WIDTH),
    parameter int IDX_W      = $clog2(WIDTH / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [7:0]       ld_byte,
    input  logic             start,
    input  logic             start_dir,
    input  logic [CNT_W-1:0] start_amt,
    output logic [WIDTH-1:0] opnd,
    output logic             busy
);

    localparam int NBYTE = WIDTH / 8;
    localparam logic [CNT_W-1:0] FIRST_W = CNT_W'(FIRST_STEP);
    localparam logic [CNT_W-1:0] NEXT_W  = CNT_W'(NEXT_STEP);
    localparam int MAX_CYC = 1 + (WIDTH - 1 - FIRST_STEP + NEXT_STEP - 1) / NEXT_STEP;

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic [CNT_W-1:0] rem;
        logic             busy;
        logic             first;
        logic             dir;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [CNT_W-1:0] step_d;
    logic [CNT_W-1:0] take_d;

    always_comb begin
        eng_d  = eng_q;
        step_d = eng_q.first ? FIRST_W : NEXT_W;
        take_d = (eng_q.rem < step_d) ? eng_q.rem : step_d;
        if (start) begin
            eng_d.busy  = 1'b1;
            eng_d.first = 1'b1;
            eng_d.rem   = start_amt;
            eng_d.dir   = start_dir;
        end else if (eng_q.busy) begin
            eng_d.val   = eng_q.dir ? (eng_q.val >> take_d) : (eng_q.val << take_d);
            eng_d.rem   = eng_q.rem - take_d;
            eng_d.first = 1'b0;
            eng_d.busy  = (eng_q.rem != take_d);
        end else if (ld_en) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (ld_idx == IDX_W'(b)) eng_d.val[b*8 +: 8] = ld_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign opnd = eng_q.val;
    assign busy = eng_q.busy;

    // Cycles spent busy since the latest start, for the bound check
    logic [7:0] run_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          run_cnt_q <= '0;
        else if (start)      run_cnt_q <= '0;
        else if (eng_q.busy) run_cnt_q <= run_cnt_q + 8'd1;
    end

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt_q < 8'(MAX_CYC)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !ld_en) |=> $stable(opnd));

endmodule

// File: rtl/shnorm_seqchk.sv
module shnorm_seqchk #(
    parameter int NBYTE = 4,
    parameter int IDX_W = $clog2(NBYTE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_md,
    input  logic             rd_md,
    input  logic [IDX_W-1:0] md_idx,
    input  logic             wr_ctl,
    input  logic             rd_ctl,
    input  logic             busy,
    output logic             err
);

    localparam int PTR_W = $clog2(NBYTE + 1);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(NBYTE);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic             set_d;
    logic [PTR_W-1:0] idx_x;
    logic [PTR_W-1:0] wexp_d;
    logic [PTR_W-1:0] rexp_d;
    logic             rmid_d;

    always_comb begin
        seq_d  = seq_q;
        set_d  = 1'b0;
        idx_x  = PTR_W'(md_idx);
        wexp_d = (seq_q.wptr == FULL) ? '0 : seq_q.wptr;
        rexp_d = (seq_q.rptr == FULL) ? '0 : seq_q.rptr;
        rmid_d = (seq_q.rptr != '0) && (seq_q.rptr != FULL);

        if ((wr_md || rd_md) && busy) begin
            set_d = 1'b1;
        end else if (wr_md) begin
            if (rmid_d) begin
                set_d      = 1'b1;
                seq_d.rptr = '0;
            end
            if (idx_x == '0)          seq_d.wptr = PTR_W'(1);
            else if (idx_x == wexp_d) seq_d.wptr = wexp_d + PTR_W'(1);
            else begin
                set_d      = 1'b1;
                seq_d.wptr = '0;
            end
        end else if (rd_md) begin
            if (idx_x == '0)          seq_d.rptr = PTR_W'(1);
            else if (idx_x == rexp_d) seq_d.rptr = rexp_d + PTR_W'(1);
            else begin
                set_d      = 1'b1;
                seq_d.rptr = '0;
            end
        end

        if (wr_ctl) begin
            if ((seq_q.wptr != FULL) || rmid_d) set_d = 1'b1;
            seq_d.wptr = '0;
            seq_d.rptr = '0;
        end

        seq_d.err = set_d || (seq_q.err && !rd_ctl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign err = seq_q.err;

    // R7
    busy_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_md || rd_md)) |=> err);

    // R11
    ctl_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |=> !err);

    // R8
    start_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && (seq_q.wptr != FULL)) |=> err);

endmodule

// File: rtl/shnorm_unit.sv
module shnorm_unit
    import shnorm_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int FIRST_STEP = 4,
    parameter int NEXT_STEP  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              busy
);

    localparam int NBYTE = WIDTH / 8;
    localparam int IDX_W = $clog2(NBYTE);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [ADDR_W-1:0] MD_LIMIT = ADDR_W'(NBYTE);

    typedef struct packed {
        logic             dir;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             is_md, wr_md, rd_md, wr_ctl, rd_ctl;
    logic [IDX_W-1:0] md_idx;
    logic             is_norm;
    logic [CNT_W-1:0] lz;
    logic [CNT_W-1:0] eng_amt;
    logic             eng_dir;
    logic [WIDTH-1:0] opnd;
    logic             eng_busy;
    logic             err;
    logic [7:0]       lane [NBYTE];

    // Bus decode: a write strobe masks a simultaneous read
    assign is_md  = bus_addr < MD_LIMIT;
    assign md_idx = bus_addr[IDX_W-1:0];
    assign wr_md  = bus_wr && is_md;
    assign rd_md  = bus_rd && !bus_wr && is_md;
    assign wr_ctl = bus_wr && (bus_addr == ADR_CTRL);
    assign rd_ctl = bus_rd && !bus_wr && (bus_addr == ADR_CTRL);

    assign is_norm = (bus_wdata[CNT_W-1:0] == '0);
    assign eng_amt = is_norm ? lz : bus_wdata[CNT_W-1:0];
    assign eng_dir = !is_norm && bus_wdata[CTL_DIR];

    shnorm_lzc #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_lzc (
        .val (opnd),
        .lz  (lz)
    );

    shnorm_engine #(
        .WIDTH(WIDTH), .FIRST_STEP(FIRST_STEP), .NEXT_STEP(NEXT_STEP),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (wr_md),
        .ld_idx    (md_idx),
        .ld_byte   (bus_wdata),
        .start     (wr_ctl),
        .start_dir (eng_dir),
        .start_amt (eng_amt),
        .opnd      (opnd),
        .busy      (eng_busy)
    );

    shnorm_seqchk #(.NBYTE(NBYTE), .IDX_W(IDX_W)) u_seqchk (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_md  (wr_md),
        .rd_md  (rd_md),
        .md_idx (md_idx),
        .wr_ctl (wr_ctl),
        .rd_ctl (rd_ctl),
        .busy   (eng_busy),
        .err    (err)
    );

    // Control register: flags are hardware-owned
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) begin
            ctl_d.dir = bus_wdata[CTL_DIR];
            ctl_d.cnt = eng_amt;
            ctl_d.ovf = is_norm && opnd[WIDTH-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Byte lanes of the operand for the read mux
    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign lane[g] = opnd[g*8 +: 8];
    end

    always_comb begin
        bus_rdata = '0;
        if (is_md) begin
            bus_rdata = lane[md_idx];
        end else if (bus_addr == ADR_CTRL) begin
            bus_rdata[CTL_ERR]     = err;
            bus_rdata[CTL_OVF]     = ctl_q.ovf;
            bus_rdata[CTL_DIR]     = ctl_q.dir;
            bus_rdata[CNT_W-1:0]   = ctl_q.cnt;
        end
    end

    assign busy = eng_busy;

    // R6
    ovf_on_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && is_norm && opnd[WIDTH-1]) |=> ctl_q.ovf);

endmodule

// File: tb/shnorm_unit_bench.sv
module shnorm_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       busy;
    logic       rd_chk = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] e;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    shnorm_unit u_shnorm_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a falling edge, return at the next one
    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.a = a; it.e = e; it.tag = tag;
        sbq.push_back(it);
        bus_addr = a; bus_rd = 1'b1; rd_chk = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; rd_chk = 1'b0;
    endtask

    task automatic brd_nochk(input logic [2:0] a);
        bus_addr = a; bus_rd = 1'b1; rd_chk = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load(input logic [31:0] v);
        for (int b = 0; b < 4; b++) bwr(3'(b), v[b*8 +: 8]);
    endtask

    task automatic read_all(input logic [31:0] v, input string tag);
        for (int b = 0; b < 4; b++) brd(3'(b), v[b*8 +: 8], tag);
    endtask

    task automatic run_done(input int exp_cyc, input string tag);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n, exp_cyc, tag);
    endtask

    function automatic int cyc(input int n);
        return (n <= 4) ? 1 : 1 + (n - 4 + 5) / 6;
    endfunction

    function automatic int lzc(input logic [31:0] v);
        int z = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return z;
            z++;
        end
        return 0;
    endfunction

    // Monitor: pops one expectation per checked read, sampled before the rising edge
    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            #8;
            if (bus_rd && rd_chk) begin
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual %02h expected none", bus_rdata);
                end else begin
                    it = sbq.pop_front();
                    if (bus_rdata !== it.e) begin
                        errors++;
                        $display("FAIL %s addr %0d actual %02h expected %02h",
                                 it.tag, it.a, bus_rdata, it.e);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        int z;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(int'(busy), 0, "R1 busy after reset");
        brd(3'd4, 8'h00, "R1 control after reset");
        read_all(32'h0, "R1 operand after reset");

        // R3 R4 left shift by 8
        load(32'h12345678);
        bwr(3'd4, 8'h08);
        run_done(cyc(8), "R4 busy length N=8");
        read_all(32'h34567800, "R3 left 8 result");
        brd(3'd4, 8'h08, "R2 control after left 8");

        // R3 R4 right shift by 31, longest case
        load(32'h80000001);
        bwr(3'd4, 8'h3F);
        run_done(6, "R4 busy length N=31");
        read_all(32'h00000001, "R3 right 31 result");
        brd(3'd4, 8'h3F, "R2 control after right 31");

        // R4 four-place shift needs one cycle
        load(32'h0000000F);
        bwr(3'd4, 8'h04);
        run_done(1, "R4 busy length N=4");
        read_all(32'h000000F0, "R3 left 4 result");

        // R5 normalize, direction bit set but ignored
        v = 32'h00001234;
        z = lzc(v);
        load(v);
        bwr(3'd4, 8'h20);
        run_done(cyc(z), "R5 normalize busy length");
        read_all(v << z, "R5 normalize result");
        brd(3'd4, 8'h20 | 8'(z), "R5 normalize count field");

        // R5 all-zero normalize
        load(32'h0);
        bwr(3'd4, 8'h20);
        run_done(1, "R5 zero normalize busy");
        read_all(32'h0, "R5 zero normalize result");
        brd(3'd4, 8'h20, "R5 zero normalize count");

        // R6 overflow on normalize with top bit set
        load(32'h80FF0000);
        bwr(3'd4, 8'h00);
        run_done(1, "R6 overflow normalize busy");
        read_all(32'h80FF0000, "R6 operand unchanged");
        brd(3'd4, 8'h40, "R6 overflow flag set");

        // R6 R2 next start clears overflow; written bits 7:6 ignored
        load(32'h00000001);
        bwr(3'd4, 8'hC1);
        run_done(1, "R6 busy after clear start");
        brd(3'd4, 8'h01, "R6 overflow cleared, R2 flag bits not writable");
        read_all(32'h00000002, "R3 left 1 result");

        // R7 read while busy
        load(32'h0F0F0F0F);
        bwr(3'd4, 8'h3F);
        brd_nochk(3'd0);
        run_done(5, "R7 busy after read-in-busy");
        read_all(32'h0, "R7 result of right 31");
        brd(3'd4, 8'hBF, "R7 error after read while busy");
        brd(3'd4, 8'h3F, "R11 error cleared by control read");

        // R7 write while busy is ignored
        load(32'h00000001);
        bwr(3'd4, 8'h1F);
        bwr(3'd3, 8'hFF);
        run_done(5, "R7 busy after write-in-busy");
        read_all(32'h80000000, "R7 write while busy ignored");
        brd(3'd0, 8'h00, "R11 error survives operand read");
        brd(3'd4, 8'h9F, "R7 error after write while busy");
        brd(3'd4, 8'h1F, "R11 error cleared");

        // Collision: access in the last busy cycle
        load(32'h000000AB);
        bwr(3'd4, 8'h04);
        chk(int'(busy), 1, "R4 busy high in single shift cycle");
        brd_nochk(3'd0);
        chk(int'(busy), 0, "R4 busy low after last cycle");
        read_all(32'h00000AB0, "R3 result with last-cycle access");
        brd(3'd4, 8'h84, "R7 error from last-cycle access");
        brd(3'd4, 8'h04, "R11 error cleared after collision");

        // R8 start after partial load
        bwr(3'd0, 8'h11);
        bwr(3'd1, 8'h22);
        bwr(3'd4, 8'h01);
        run_done(1, "R8 busy after partial load start");
        brd(3'd4, 8'h81, "R8 error on partial load start");
        brd(3'd4, 8'h01, "R11 clear after R8");

        // R9 out-of-order write
        bwr(3'd1, 8'h55);
        brd(3'd4, 8'h81, "R9 error on out-of-order write");
        brd(3'd4, 8'h01, "R11 clear after R9 write");

        // R10 write during partial read-out
        load(32'h11223344);
        bwr(3'd4, 8'h01);
        run_done(1, "R3 busy left 1");
        brd(3'd0, 8'h88, "R10 read MD0");
        brd(3'd1, 8'h66, "R10 read MD1");
        brd(3'd4, 8'h01, "R10 no error before interruption");
        bwr(3'd0, 8'h00);
        brd(3'd4, 8'h81, "R10 error on write during read-out");

        // R9 out-of-order read
        brd(3'd2, 8'h44, "R9 MD2 content");
        brd(3'd4, 8'h81, "R9 error on out-of-order read");
        brd(3'd4, 8'h01, "R11 clear after R9 read");

        // R8 start during partial read-out
        load(32'h00000003);
        brd(3'd0, 8'h03, "R8 read MD0 before start");
        bwr(3'd4, 8'h02);
        run_done(1, "R8 busy after start in read-out");
        read_all(32'h0000000C, "R3 left 2 result");
        brd(3'd4, 8'h82, "R8 error on start during read-out");
        brd(3'd4, 8'h02, "R11 clear after R8 read-out");

        @(negedge clk);
        chk(sbq.size(), 0, "scoreboard drained");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule